// File: doc/BRIEF.md
# HDLC Transmit Controller with Byte FIFO

This block turns bytes written by a host into a bit-serial HDLC stream. Bytes enter a 64-entry FIFO. The serializer wraps each packet in an opening and a closing flag, appends a 16-bit frame check sequence and inserts a zero after every run of five ones inside the packet body. Between packets it sends fill, which is either flag bytes or all-ones idle bytes. One output bit leaves per cycle in which `bit_en` is high. Between enables, every piece of serializer state holds still.

The host marks the last byte of a packet by pulsing `eom_set` before writing that byte. `eom_pend` stays high until that byte has left the serializer. Two level commands act only on their rising edge:
- **Abort** empties the FIFO and sends one FEh byte.
- **Transmit reset** empties the FIFO and returns the serializer to fill.

Two defeat levels switch off bit stuffing and the check sequence independently. If the FIFO runs dry inside a packet, the packet is ended with the abort byte and the underrun status is raised.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: Between packets, fill bytes go out continuously: 7Eh while `fill_ones`=0 and FFh while `fill_ones`=1. The choice is taken each time a new fill byte starts.
- R2: A rising edge of `abort_cmd` empties the FIFO and drops a write made in that cycle. At the next byte boundary exactly one FEh is sent, followed by fill. While `abort_cmd` stays high no further abort byte is sent; it must go low and high again.
- R3: The first byte written after `eom_set` while `eom_pend`=1 is the packet's last data byte. `eom_pend` returns to 0 when the serializer moves past that byte. `st_msg_end` rises when the closing flag starts (or on underrun) and clears when the next opening flag starts.
- R4: With `no_stuff`=0, a 0 is inserted after every five consecutive 1s in the data and check-sequence fields. This also happens when the run ends on the field's last bit. No 0 is ever inserted in flags, fill or the abort byte.
- R5: Every byte is sent least significant bit first. With `no_crc`=0, a packet is 7Eh, the data bytes, the check sequence (low byte, then high byte) and 7Eh. The check sequence is the complement of a CRC-16 with polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset to FFFFh and run over the data bits.
- R6: With `no_stuff`=1, no zero is inserted anywhere.
- R7: With `no_crc`=1, the closing flag follows the last data byte directly.
- R8: The FIFO holds 64 bytes and ignores writes while full. The status outputs mean:
  - `st_full`: 64 bytes are stored.
  - `st_half`: 32 or fewer bytes are stored.
  - `st_notfull`: the inverse of `st_full`.
  - `st_empty`: no byte is stored.
- R9: If the FIFO is empty at a byte boundary inside a packet, before the marked byte, FEh is sent and then fill. `st_underrun` and `st_msg_end` both go to 1, and both clear at the next opening flag.
- R10: A rising edge of `reset_cmd` empties the FIFO, clears `eom_pend` and both flags, sets `tx_bit` to 1 and restarts the serializer in fill. A held-high level has no further effect.
- R11: The serializer advances only on cycles with `bit_en`=1, one line bit per such cycle, and `tx_bit` holds otherwise.
- R12: A packet starts at the first byte boundary in fill, or after a closing or abort byte, at which the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance the serial output by one bit |
| wr_en | input | 1 | Host write strobe into the FIFO |
| wr_data | input | 8 | Byte to write |
| eom_set | input | 1 | Pulse: the next write is the packet's last byte |
| fill_ones | input | 1 | Fill select: 0 flags, 1 all-ones idle |
| no_stuff | input | 1 | 1 disables zero insertion |
| no_crc | input | 1 | 1 omits the check sequence |
| abort_cmd | input | 1 | Abort, acts on rising edge |
| reset_cmd | input | 1 | Transmit reset, acts on rising edge |
| tx_bit | output | 1 | Serial line output |
| eom_pend | output | 1 | End-of-message marker still outstanding |
| st_full | output | 1 | FIFO full |
| st_half | output | 1 | FIFO holds half or less |
| st_notfull | output | 1 | FIFO can take a write |
| st_empty | output | 1 | FIFO empty |
| st_underrun | output | 1 | Last packet was cut short by starvation |
| st_msg_end | output | 1 | Packet finished |

## Verification
The assertions take the following for granted about the inputs:
- `reset_cmd` and `abort_cmd` are levels synchronous to `clk`, so that a rising edge is seen in exactly one cycle.
- `eom_set` is pulsed before, not with, the write it marks.
- `bit_en` qualifies a single cycle.

The stimulus meets these assumptions by driving every input on the falling clock edge. It holds command levels for many cycles and pulses `eom_set` alone one cycle ahead of the marked write. It runs `bit_en` continuous, at one cycle in three, and held low, so that the freeze and FIFO-fill cases are reached.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    FLD_FILL  = 3'd0,
    FLD_OPEN  = 3'd1,
    FLD_DATA  = 3'd2,
    FLD_CRCL  = 3'd3,
    FLD_CRCH  = 3'd4,
    FLD_CLOSE = 3'd5,
    FLD_ABORT = 3'd6
  } fld_e;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  IDLE_BYTE  = 8'hFF;
  localparam logic [7:0]  ABORT_BYTE = 8'hFE;
  localparam logic [15:0] FCS_INIT   = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_R = 16'h8408;
  localparam int          STUFF_RUN  = 5;

  // one bit of the reflected CRC-16 update
  function automatic logic [15:0] fcs_step(input logic [15:0] cur, input logic din);
    logic fb;
    fb = cur[0] ^ din;
    fcs_step = {1'b0, cur[15:1]} ^ (fb ? FCS_POLY_R : 16'h0000);
  endfunction

  function automatic logic stuffable(input fld_e f);
    stuffable = (f == FLD_DATA) || (f == FLD_CRCL) || (f == FLD_CRCH);
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [WIDTH-1:0]               push_data,
  input  logic                           pop,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH):0]         count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CNT_W-1:0] cnt_n;
  logic             do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = count;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (do_push) wr_ptr_n = wr_ptr + AW'(1);
      if (do_pop)  rd_ptr_n = rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_n = count + CNT_W'(1);
        2'b01:   cnt_n = count - CNT_W'(1);
        default: cnt_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       soft_rst,
  input  logic       abort_req,
  input  logic       fill_ones,
  input  logic       no_stuff,
  input  logic       no_crc,
  input  logic       fifo_empty,
  input  logic [8:0] fifo_head,
  output logic       fifo_pop,
  output logic       last_sent,
  output logic       tx_bit,
  output logic       msg_end,
  output logic       underrun
);
  logic [7:0]  sh, sh_n, wbyte;
  logic [3:0]  cnt, cnt_n, wcnt;
  fld_e        fld, fld_n, wfld;
  logic [2:0]  ones, ones_n;
  logic [15:0] crc, crc_n;
  logic        tag, tag_n, abt, abt_n, txb_n, mend_n, urun_n, take;

  always_comb begin
    sh_n = sh; cnt_n = cnt; fld_n = fld; ones_n = ones; crc_n = crc;
    tag_n = tag; abt_n = abt | abort_req; txb_n = tx_bit;
    mend_n = msg_end; urun_n = underrun;
    fifo_pop = 1'b0; last_sent = 1'b0; take = 1'b0;
    wbyte = sh; wcnt = cnt; wfld = fld;
    if (bit_en) begin
      if (!no_stuff && ones == 3'(STUFF_RUN)) begin
        txb_n  = 1'b0;
        ones_n = '0;
      end else begin
        if (cnt == '0) begin
          wcnt = 4'd8;
          if (abt) begin
            wbyte = ABORT_BYTE; wfld = FLD_ABORT; abt_n = abort_req;
          end else begin
            case (fld)
              FLD_OPEN: take = 1'b1;
              FLD_DATA: begin
                if (tag) begin
                  last_sent = 1'b1;
                  if (!no_crc) begin
                    wbyte = ~crc[7:0]; wfld = FLD_CRCL;
                  end else begin
                    wbyte = FLAG_BYTE; wfld = FLD_CLOSE; mend_n = 1'b1;
                  end
                end else take = 1'b1;
              end
              FLD_CRCL: begin wbyte = ~crc[15:8]; wfld = FLD_CRCH; end
              FLD_CRCH: begin wbyte = FLAG_BYTE; wfld = FLD_CLOSE; mend_n = 1'b1; end
              default: begin
                if (!fifo_empty) begin
                  wbyte = FLAG_BYTE; wfld = FLD_OPEN; crc_n = FCS_INIT;
                  mend_n = 1'b0; urun_n = 1'b0;
                end else begin
                  wbyte = fill_ones ? IDLE_BYTE : FLAG_BYTE; wfld = FLD_FILL;
                end
              end
            endcase
            if (take) begin
              if (!fifo_empty) begin
                wbyte = fifo_head[7:0]; tag_n = fifo_head[8];
                fifo_pop = 1'b1; wfld = FLD_DATA;
              end else begin
                wbyte = ABORT_BYTE; wfld = FLD_ABORT;
                urun_n = 1'b1; mend_n = 1'b1;
              end
            end
          end
        end
        txb_n = wbyte[0];
        sh_n  = {1'b0, wbyte[7:1]};
        cnt_n = wcnt - 4'd1;
        fld_n = wfld;
        if (stuffable(wfld) && !no_stuff) ones_n = wbyte[0] ? ones + 3'd1 : 3'd0;
        else                              ones_n = '0;
        if (wfld == FLD_DATA) crc_n = fcs_step(crc, wbyte[0]);
      end
    end
    if (soft_rst) begin
      sh_n = '0; cnt_n = '0; fld_n = FLD_FILL; ones_n = '0; crc_n = FCS_INIT;
      tag_n = 1'b0; abt_n = 1'b0; txb_n = 1'b1; mend_n = 1'b0; urun_n = 1'b0;
      fifo_pop = 1'b0; last_sent = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; fld <= FLD_FILL; ones <= '0; crc <= FCS_INIT;
      tag <= 1'b0; abt <= 1'b0; tx_bit <= 1'b1; msg_end <= 1'b0; underrun <= 1'b0;
    end else begin
      sh <= sh_n; cnt <= cnt_n; fld <= fld_n; ones <= ones_n; crc <= crc_n;
      tag <= tag_n; abt <= abt_n; tx_bit <= txb_n; msg_end <= mend_n; underrun <= urun_n;
    end
  end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
  parameter int FIFO_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eom_set,
  input  logic       fill_ones,
  input  logic       no_stuff,
  input  logic       no_crc,
  input  logic       abort_cmd,
  input  logic       reset_cmd,
  output logic       tx_bit,
  output logic       eom_pend,
  output logic       st_full,
  output logic       st_half,
  output logic       st_notfull,
  output logic       st_empty,
  output logic       st_underrun,
  output logic       st_msg_end
);
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1;
  localparam int HALF_MARK = FIFO_DEPTH / 2;

  logic             rst_prev, abt_prev, rst_edge, abort_edge, flush;
  logic             eom_armed, eom_pend_n, eom_armed_n, tag_wr, accept;
  logic             pop, last_sent;
  logic [8:0]       head;
  logic [CNT_W-1:0] count;

  assign rst_edge   = reset_cmd & ~rst_prev;
  assign abort_edge = abort_cmd & ~abt_prev;
  assign flush      = rst_edge | abort_edge;
  assign accept     = wr_en & ~st_full & ~flush;
  assign tag_wr     = eom_pend & ~eom_armed;

  assign st_full    = (count == CNT_W'(FIFO_DEPTH));
  assign st_half    = (count <= CNT_W'(HALF_MARK));
  assign st_notfull = ~st_full;
  assign st_empty   = (count == '0);

  always_comb begin
    eom_pend_n  = eom_pend;
    eom_armed_n = eom_armed;
    if (flush) begin
      eom_pend_n  = 1'b0;
      eom_armed_n = 1'b0;
    end else begin
      if (eom_set)        eom_pend_n = 1'b1;
      else if (last_sent) eom_pend_n = 1'b0;
      if (accept && tag_wr) eom_armed_n = 1'b1;
      else if (last_sent)   eom_armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev  <= 1'b0;
      abt_prev  <= 1'b0;
      eom_pend  <= 1'b0;
      eom_armed <= 1'b0;
    end else begin
      rst_prev  <= reset_cmd;
      abt_prev  <= abort_cmd;
      eom_pend  <= eom_pend_n;
      eom_armed <= eom_armed_n;
    end
  end

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(9)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (accept),
    .push_data ({tag_wr, wr_data}),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  hdlc_tx_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .soft_rst   (rst_edge),
    .abort_req  (abort_edge),
    .fill_ones  (fill_ones),
    .no_stuff   (no_stuff),
    .no_crc     (no_crc),
    .fifo_empty (st_empty),
    .fifo_head  (head),
    .fifo_pop   (pop),
    .last_sent  (last_sent),
    .tx_bit     (tx_bit),
    .msg_end    (st_msg_end),
    .underrun   (st_underrun)
  );

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic eom_set,
  input logic tx_bit,
  input logic eom_pend,
  input logic st_full,
  input logic st_half,
  input logic st_notfull,
  input logic st_empty,
  input logic st_underrun,
  input logic st_msg_end,
  input logic rst_edge,
  input logic abort_edge,
  input logic last_sent
);

  assert_hold_without_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !rst_edge) |=> $stable(tx_bit));

  assert_full_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> (!st_empty && !st_notfull && !st_half));

  assert_eom_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_sent && !eom_set) |=> !eom_pend);

  assert_underrun_ends_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_underrun |-> st_msg_end);

  assert_reset_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_edge |=> (st_empty && !eom_pend && !st_underrun && tx_bit));

  assert_abort_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_edge |=> (st_empty && !eom_pend));

endmodule

bind hdlc_tx_ctrl hdlc_tx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .eom_set     (eom_set),
  .tx_bit      (tx_bit),
  .eom_pend    (eom_pend),
  .st_full     (st_full),
  .st_half     (st_half),
  .st_notfull  (st_notfull),
  .st_empty    (st_empty),
  .st_underrun (st_underrun),
  .st_msg_end  (st_msg_end),
  .rst_edge    (rst_edge),
  .abort_edge  (abort_edge),
  .last_sent   (last_sent)
);

// File: tb/hdlc_tx_ctrl_tb_top.sv
module hdlc_tx_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int K_FILL = 0, K_OPEN = 1, K_DATA = 2, K_CRCL = 3,
                 K_CRCH = 4, K_CLOSE = 5, K_ABORT = 6;

  logic clk = 1'b0;
  logic rst_n, bit_en, wr_en, eom_set, fill_ones, no_stuff, no_crc, abort_cmd, reset_cmd;
  logic [7:0] wr_data;
  logic tx_bit, eom_pend, st_full, st_half, st_notfull, st_empty, st_underrun, st_msg_end;

  int    checks = 0, errors = 0, en_mode = 0, en_cnt = 0;
  bit    chk_on = 0, fin = 0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
    .eom_set(eom_set), .fill_ones(fill_ones), .no_stuff(no_stuff), .no_crc(no_crc),
    .abort_cmd(abort_cmd), .reset_cmd(reset_cmd), .tx_bit(tx_bit), .eom_pend(eom_pend),
    .st_full(st_full), .st_half(st_half), .st_notfull(st_notfull), .st_empty(st_empty),
    .st_underrun(st_underrun), .st_msg_end(st_msg_end));

  // ---------------- reference model ----------------
  logic [8:0]  q[$];
  logic        fb[$];
  int          m_fk, m_ones;
  logic [15:0] m_crc;
  logic        m_tag, m_abt, m_txb, m_mend, m_urun, m_eom, m_armed, m_last, p_rst, p_abt;

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) fb.push_back(b[i]);
  endtask

  task automatic m_ser_reset();
    fb.delete(); m_fk = K_FILL; m_ones = 0; m_crc = 16'hFFFF; m_tag = 0;
    m_abt = 0; m_txb = 1; m_mend = 0; m_urun = 0;
  endtask

  task automatic m_take();
    logic [8:0] e;
    if (q.size() > 0) begin
      e = q.pop_front(); add_byte(e[7:0]); m_tag = e[8]; m_fk = K_DATA;
    end else begin
      add_byte(8'hFE); m_fk = K_ABORT; m_urun = 1; m_mend = 1;
    end
  endtask

  task automatic m_load();
    if (m_abt) begin
      m_abt = 0; add_byte(8'hFE); m_fk = K_ABORT;
    end else if (m_fk == K_OPEN) m_take();
    else if (m_fk == K_DATA) begin
      if (m_tag) begin
        m_last = 1;
        if (!no_crc) begin add_byte(~m_crc[7:0]); m_fk = K_CRCL; end
        else begin add_byte(8'h7E); m_fk = K_CLOSE; m_mend = 1; end
      end else m_take();
    end else if (m_fk == K_CRCL) begin
      add_byte(~m_crc[15:8]); m_fk = K_CRCH;
    end else if (m_fk == K_CRCH) begin
      add_byte(8'h7E); m_fk = K_CLOSE; m_mend = 1;
    end else if (q.size() > 0) begin
      add_byte(8'h7E); m_fk = K_OPEN; m_crc = 16'hFFFF; m_mend = 0; m_urun = 0;
    end else begin
      add_byte(fill_ones ? 8'hFF : 8'h7E); m_fk = K_FILL;
    end
  endtask

  task automatic m_step();
    logic b, f;
    if (!no_stuff && m_ones == 5) begin
      m_txb = 0; m_ones = 0;
    end else begin
      if (fb.size() == 0) m_load();
      b = fb.pop_front();
      m_txb = b;
      if (!no_stuff && (m_fk == K_DATA || m_fk == K_CRCL || m_fk == K_CRCH))
        m_ones = b ? m_ones + 1 : 0;
      else m_ones = 0;
      if (m_fk == K_DATA) begin
        f = m_crc[0] ^ b; m_crc = m_crc >> 1;
        if (f) m_crc = m_crc ^ 16'h8408;
      end
    end
  endtask

  always @(posedge clk) begin : model
    logic re, ae, tagw;
    int   sz0;
    if (!rst_n) begin
      m_ser_reset(); q.delete(); m_eom = 0; m_armed = 0; p_rst = 0; p_abt = 0;
    end else begin
      re = reset_cmd && !p_rst; ae = abort_cmd && !p_abt;
      p_rst = reset_cmd; p_abt = abort_cmd;
      if (re) begin
        m_ser_reset(); q.delete(); m_eom = 0; m_armed = 0;
      end else begin
        sz0 = q.size(); tagw = m_eom && !m_armed; m_last = 0;
        if (bit_en) m_step();
        if (ae) begin
          m_abt = 1; q.delete(); m_eom = 0; m_armed = 0;
        end else begin
          if (wr_en && sz0 < DEPTH) begin
            q.push_back({tagw, wr_data});
            if (tagw) m_armed = 1; else if (m_last) m_armed = 0;
          end else if (m_last) m_armed = 0;
          if (eom_set) m_eom = 1; else if (m_last) m_eom = 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  function automatic void chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      chk(cur_req, "tx_bit", tx_bit, m_txb);
      chk("R8", "st_full", st_full, q.size() == DEPTH);
      chk("R8", "st_half", st_half, q.size() <= DEPTH/2);
      chk("R8", "st_notfull", st_notfull, q.size() != DEPTH);
      chk("R8", "st_empty", st_empty, q.size() == 0);
      chk("R9", "st_underrun", st_underrun, m_urun);
      chk("R3", "st_msg_end", st_msg_end, m_mend);
      chk("R3", "eom_pend", eom_pend, m_eom);
    end
  end

  // bit enable pattern: 0 = every cycle, -1 = never, n = one in n
  always @(negedge clk) begin
    en_cnt = en_cnt + 1;
    if (en_mode == 0)      bit_en = 1'b1;
    else if (en_mode < 0)  bit_en = 1'b0;
    else                   bit_en = (en_cnt % en_mode) == 0;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic mark_eom();
    eom_set = 1'b1; @(negedge clk); eom_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; eom_set = 0; fill_ones = 0; no_stuff = 0;
    no_crc = 0; abort_cmd = 0; reset_cmd = 0;
    tick(5);
    rst_n = 1;
    tick(1);
    chk_on = 1;                               // reset state: R10 label on first compares

    cur_req = "R1";  tick(40);                // flag fill
    fill_ones = 1;   tick(40);                // idle fill
    fill_ones = 0;   tick(20);

    cur_req = "R5";                           // normal packet with check sequence
    put(8'h12); put(8'h34); mark_eom(); put(8'h56);
    tick(150);

    cur_req = "R4";                           // long runs of ones force insertion
    put(8'hFF); put(8'hFF); put(8'h3F); mark_eom(); put(8'h7C);
    tick(200);

    cur_req = "R6";  no_stuff = 1;
    put(8'hFF); put(8'hFF); put(8'h3F); mark_eom(); put(8'h7C);
    tick(200);       no_stuff = 0;

    cur_req = "R7";  no_crc = 1;
    put(8'hA5); mark_eom(); put(8'h5A);
    tick(150);       no_crc = 0;

    cur_req = "R11"; en_mode = 3;             // sparse enables
    put(8'hF8); mark_eom(); put(8'h1F);
    tick(400);       en_mode = 0;

    cur_req = "R9";                           // starvation without end marker
    put(8'hC3); put(8'h3C);
    tick(150);

    cur_req = "R12";                          // next packet clears flags
    mark_eom(); put(8'h81);
    tick(150);

    cur_req = "R2";                           // abort mid packet
    put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h05); mark_eom(); put(8'h06);
    tick(24);
    abort_cmd = 1;   tick(60);
    put(8'h77); mark_eom(); put(8'h88);       // level held: no second abort
    tick(150);
    abort_cmd = 0;   fill_ones = 1; tick(10);
    abort_cmd = 1;   tick(40);                // abort during idle fill
    abort_cmd = 0;   fill_ones = 0; tick(20);

    cur_req = "R8";  en_mode = -1;            // frozen serializer, fill the FIFO
    for (int i = 0; i < 65; i++) put(8'(i * 7 + 3));
    tick(3);
    chk("R8", "full after 65 writes", st_full, 1'b1);

    cur_req = "R10";
    mark_eom();
    reset_cmd = 1;   tick(3);
    chk("R10", "empty after reset edge", st_empty, 1'b1);
    en_mode = 0;     tick(50);                // level held: no further effect
    put(8'hAA);      tick(10);
    reset_cmd = 0;   tick(120);

    cur_req = "R8";  en_mode = -1;            // half threshold
    for (int i = 0; i < 32; i++) put(8'(i));
    chk("R8", "half at 32", st_half, 1'b1);
    put(8'h55);
    chk("R8", "half at 33", st_half, 1'b0);
    cur_req = "R10"; reset_cmd = 1; tick(2); reset_cmd = 0; en_mode = 0;
    tick(40);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule